// File: doc/BRIEF.md
# SDRAM Write-Burst Bank Model

This block is a synthesizable stand-in for the device side of an SDRAM, built to exercise a memory controller's write path. It watches the command bus and keeps one open row per bank. A write burst steps a column counter through a small word array and stores each beat unless the mask input is high on that edge. A new write, a read or a precharge can cut a write burst short, and each of these has its own rule for which beats are kept. A read returns stored words after a fixed CAS latency.

The model also judges the controller's timing. It pulses a contention flag when the controller drives the data bus while the model is returning read data, or in the turnaround cycle just before the first read word. It pulses a timing-error flag when a precharge comes before write recovery has expired, or when an activate comes before precharge time has elapsed. Refresh and analog timing are not modelled.

Top module: `sdram_wr_model`

## Requirements
- R1: After reset, dq_oe, contention and timing_err are low, dq_out is zero, and every array word reads as zero.
- R2: Command codes on cmd are 0 no-op, 1 activate, 2 read, 3 write and 4 precharge; codes 5 to 7 act as no-op. Activate latches addr[ROW_W-1:0] as the open row of the selected bank. Write stores dq_in on its own edge at column addr, then stores BURST_LEN-1 further beats on the following edges. Only the low log2(BURST_LEN) column bits advance, by one per beat, and they wrap inside the aligned block.
- R3: A beat whose edge sees dqm high is not stored, and the burst still moves on to the next column.
- R4: A write that arrives during a write burst ends the old burst at once. The beat on that edge is beat 0 of the new burst.
- R5: A read that arrives during a write burst stores neither the beat on its own edge nor any later beat of that burst.
- R6: When a read is registered on edge E, dq_oe is high in the BURST_LEN cycles that follow edges E+CAS_LAT onward. dq_out carries the words of the row open at E, starting at column addr, in the wrapped order of R2. dq_out is zero whenever dq_oe is low. A later read takes over the bus from its own start cycle. A write stops read output from its own edge.
- R7: contention is high in any cycle where dq_drv is high and either dq_oe is high or the next edge starts a read burst.
- R8: A precharge with pre_all high, or one addressed to the bank of the running write burst, ends that burst, and the beat on the precharge edge is not stored. A precharge to another bank leaves the burst running.
- R9: timing_err is high in a precharge cycle if any bank it covers stored an unmasked beat fewer than T_WR edges before the precharge edge. Masked beats do not count.
- R10: timing_err is high in an activate cycle if the selected bank was covered by a precharge fewer than T_RP edges before the activate edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands and beats are registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code (see R2) |
| bank | input | BANK_W | Bank select |
| addr | input | COL_W | Row on activate (low ROW_W bits), start column on read or write |
| pre_all | input | 1 | Precharge covers every bank |
| dqm | input | 1 | Data mask for the beat on this edge |
| dq_in | input | DATA_W | Write data from the controller |
| dq_drv | input | 1 | Controller is driving the data bus this cycle |
| dq_out | output | DATA_W | Read data from the model |
| dq_oe | output | 1 | Model is driving read data this cycle |
| contention | output | 1 | Bus contention detected this cycle |
| timing_err | output | 1 | Early precharge or early activate this cycle |

## Verification
The properties assume that the controller holds cmd at no-op while reset is asserted. They also assume that the start of read output is caused only by a read issued exactly CAS latency edges earlier. That holds as long as no write is issued in the cycle where a pending read would begin. The stimulus keeps to these limits: it issues one command per cycle from the falling edge, keeps no-ops during reset, and places writes that cancel a read only after output has begun or long before it. The recovery and precharge-time checks assume T_WR and T_RP of at least two, which the defaults meet.

// File: rtl/sdram_wr_model.sv
`timescale 1ns/1ps
module sdram_wr_model #(
  parameter int BANK_W    = 1,
  parameter int ROW_W     = 2,
  parameter int COL_W     = 4,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  addr,
  input  logic              pre_all,
  input  logic              dqm,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              dq_drv,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              contention,
  output logic              timing_err
);
  localparam int BANKS = 1 << BANK_W;
  localparam int AW    = BANK_W + ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;
  localparam int BL_W  = $clog2(BURST_LEN);
  localparam int CL_W  = $clog2(CAS_LAT + 1);
  localparam int WR_CW = $clog2(T_WR + 1);
  localparam int RP_CW = $clog2(T_RP + 1);
  localparam logic [BL_W-1:0] LAST_BEAT = BL_W'(BURST_LEN - 1);

  localparam logic [2:0] OP_ACT = 3'd1;
  localparam logic [2:0] OP_RD  = 3'd2;
  localparam logic [2:0] OP_WR  = 3'd3;
  localparam logic [2:0] OP_PRE = 3'd4;

  function automatic logic [COL_W-1:0] col_at(input logic [COL_W-1:0] base,
                                              input logic [BL_W-1:0]  beat);
    col_at = {base[COL_W-1:BL_W], base[BL_W-1:0] + beat};
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ROW_W-1:0]  open_row [BANKS];
  logic [WR_CW-1:0]  wr_rec [BANKS];
  logic [RP_CW-1:0]  rp_cnt [BANKS];

  logic              wr_act;
  logic [BANK_W-1:0] wr_bank;
  logic [ROW_W-1:0]  wr_row;
  logic [COL_W-1:0]  wr_col;
  logic [BL_W-1:0]   wr_beat;

  logic [CL_W-1:0]   rd_wait;
  logic              rd_act;
  logic [BANK_W-1:0] rd_bank, pd_bank;
  logic [ROW_W-1:0]  rd_row,  pd_row;
  logic [COL_W-1:0]  rd_col,  pd_col;
  logic [BL_W-1:0]   rd_beat;

  wire is_act = (cmd == OP_ACT);
  wire is_rd  = (cmd == OP_RD);
  wire is_wr  = (cmd == OP_WR);
  wire is_pre = (cmd == OP_PRE);

  wire wr_stop   = is_rd | is_wr | (is_pre & (pre_all | (bank == wr_bank)));
  wire cont_beat = wr_act & ~wr_stop;
  wire wen       = (is_wr | cont_beat) & ~dqm;

  wire [BANK_W-1:0] w_bank = is_wr ? bank : wr_bank;
  wire [ROW_W-1:0]  w_row  = is_wr ? open_row[bank] : wr_row;
  wire [COL_W-1:0]  w_col  = is_wr ? addr : col_at(wr_col, wr_beat);
  wire [AW-1:0]     waddr  = {w_bank, w_row, w_col};
  wire [AW-1:0]     raddr  = {rd_bank, rd_row, col_at(rd_col, rd_beat)};
  wire              rd_next = (rd_wait == CL_W'(1));

  logic pre_busy;
  always_comb begin
    pre_busy = 1'b0;
    for (int b = 0; b < BANKS; b++)
      if ((pre_all || bank == BANK_W'(b)) && wr_rec[b] != '0) pre_busy = 1'b1;
  end

  assign dq_oe      = rd_act;
  assign dq_out     = rd_act ? mem[raddr] : '0;
  assign contention = dq_drv & (rd_act | rd_next);
  assign timing_err = (is_pre & pre_busy) | (is_act & (rp_cnt[bank] != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wen) begin
      mem[waddr] <= dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++) begin
        open_row[b] <= '0;
        wr_rec[b]   <= '0;
        rp_cnt[b]   <= '0;
      end
    end else begin
      if (is_act) open_row[bank] <= addr[ROW_W-1:0];
      for (int b = 0; b < BANKS; b++) begin
        if (wen && w_bank == BANK_W'(b))  wr_rec[b] <= WR_CW'(T_WR - 1);
        else if (wr_rec[b] != '0)         wr_rec[b] <= wr_rec[b] - 1'b1;
        if (is_pre && (pre_all || bank == BANK_W'(b))) rp_cnt[b] <= RP_CW'(T_RP - 1);
        else if (rp_cnt[b] != '0)                      rp_cnt[b] <= rp_cnt[b] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act  <= 1'b0;
      wr_bank <= '0;
      wr_row  <= '0;
      wr_col  <= '0;
      wr_beat <= '0;
    end else if (is_wr) begin
      wr_act  <= 1'b1;
      wr_bank <= bank;
      wr_row  <= open_row[bank];
      wr_col  <= addr;
      wr_beat <= BL_W'(1);
    end else if (wr_act) begin
      if (wr_stop) begin
        wr_act <= 1'b0;
      end else begin
        wr_beat <= wr_beat + 1'b1;
        if (wr_beat == LAST_BEAT) wr_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_wait <= '0;
      rd_act  <= 1'b0;
      rd_beat <= '0;
      rd_bank <= '0;
      rd_row  <= '0;
      rd_col  <= '0;
      pd_bank <= '0;
      pd_row  <= '0;
      pd_col  <= '0;
    end else if (is_wr) begin
      rd_wait <= '0;
      rd_act  <= 1'b0;
    end else begin
      if (is_rd) begin
        rd_wait <= CL_W'(CAS_LAT);
        pd_bank <= bank;
        pd_row  <= open_row[bank];
        pd_col  <= addr;
      end else if (rd_wait != '0) begin
        rd_wait <= rd_wait - 1'b1;
      end
      if (rd_next) begin
        rd_act  <= 1'b1;
        rd_beat <= '0;
        rd_bank <= pd_bank;
        rd_row  <= pd_row;
        rd_col  <= pd_col;
      end else if (rd_act) begin
        rd_beat <= rd_beat + 1'b1;
        if (rd_beat == LAST_BEAT) rd_act <= 1'b0;
      end
    end
  end
endmodule

module sdram_wr_model_chk #(
  parameter int BANK_W  = 1,
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 2,
  parameter int T_WR    = 2,
  parameter int T_RP    = 3
)(
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [BANK_W-1:0] bank,
  input logic              pre_all,
  input logic              dqm,
  input logic              dq_drv,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              contention,
  input logic              timing_err
);
  a_r6_start_after_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(cmd, CAS_LAT + 1) == 3'd2);

  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == '0);

  a_r7_drive_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_drv && dq_oe) |-> contention);

  if (T_WR >= 2) begin : g_wr
    a_r9_early_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd4 && $past(cmd) == 3'd3 && !$past(dqm) && $past(bank) == bank)
        |-> timing_err);
  end

  if (T_RP >= 2) begin : g_rp
    a_r10_early_activate: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd1 && $past(cmd) == 3'd4 && ($past(pre_all) || $past(bank) == bank))
        |-> timing_err);
  end
endmodule

bind sdram_wr_model sdram_wr_model_chk #(
  .BANK_W(BANK_W), .DATA_W(DATA_W), .CAS_LAT(CAS_LAT), .T_WR(T_WR), .T_RP(T_RP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .pre_all(pre_all), .dqm(dqm),
  .dq_drv(dq_drv), .dq_out(dq_out), .dq_oe(dq_oe), .contention(contention),
  .timing_err(timing_err)
);

// File: tb/sim_sdram_wr_model.sv
`timescale 1ns/1ps
module sim_sdram_wr_model;
  localparam int BANK_W = 1, ROW_W = 2, COL_W = 4, DW = 16;
  localparam int BL = 4, CL = 2, TWR = 2, TRP = 3;
  localparam int ROWS = 1 << ROW_W, COLS = 1 << COL_W, BANKS = 1 << BANK_W;
  localparam int DEPTH = BANKS * ROWS * COLS;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [2:0] cmd;
  logic [BANK_W-1:0] bank;
  logic [COL_W-1:0] addr;
  logic pre_all, dqm, dq_drv;
  logic [DW-1:0] dq_in, dq_out;
  logic dq_oe, contention, timing_err;

  sdram_wr_model u0 (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .addr(addr), .pre_all(pre_all),
    .dqm(dqm), .dq_in(dq_in), .dq_drv(dq_drv), .dq_out(dq_out), .dq_oe(dq_oe),
    .contention(contention), .timing_err(timing_err)
  );

  int errors = 0, checks = 0, edge_no = 0;
  string cur = "R1";
  logic [DW-1:0] mem_m [DEPTH];
  int open_row [BANKS];
  int wr_last  [BANKS];
  int pre_last [BANKS];
  int wq [$];
  int wbank = 0;
  int sched [int];

  function automatic int key(int b, int r, int c);
    return (b * ROWS + r) * COLS + c;
  endfunction

  function automatic int wcol(int base, int i);
    return (base & ~(BL - 1)) | ((base + i) & (BL - 1));
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(logic [2:0] c, int b = 0, int a = 0, bit all = 0, bit m = 0,
                     logic [DW-1:0] d = '0, bit drv = 0);
    bit e_oe, e_ct, e_er;
    int en;
    cmd = c; bank = BANK_W'(b); addr = COL_W'(a); pre_all = all; dqm = m;
    dq_in = d; dq_drv = drv;
    #1;
    e_oe = sched.exists(edge_no);
    chk(cur, "dq_oe", dq_oe, e_oe);
    chk(cur, "dq_out", dq_out, e_oe ? mem_m[sched[edge_no]] : '0);
    e_ct = drv && (sched.exists(edge_no) || sched.exists(edge_no + 1));
    chk(cur, "contention", contention, e_ct);
    en = edge_no + 1;
    e_er = 1'b0;
    if (c == PRE)
      for (int bb = 0; bb < BANKS; bb++)
        if ((all || bb == b) && (en - wr_last[bb]) < TWR) e_er = 1'b1;
    if (c == ACT && (en - pre_last[b]) < TRP) e_er = 1'b1;
    chk(cur, "timing_err", timing_err, e_er);

    @(posedge clk);
    edge_no++;
    if (c == RD || c == WR || (c == PRE && (all || b == wbank))) wq.delete();
    else if (wq.size() > 0) begin
      int k = wq.pop_front();
      if (!m) begin mem_m[k] = d; wr_last[wbank] = edge_no; end
    end
    if (c == WR) begin
      int gone [$];
      for (int i = 0; i < BL; i++) begin
        int k = key(b, open_row[b], wcol(a, i));
        if (i == 0) begin
          if (!m) begin mem_m[k] = d; wr_last[b] = edge_no; end
        end else wq.push_back(k);
      end
      wbank = b;
      foreach (sched[s]) if (s >= edge_no) gone.push_back(s);
      foreach (gone[g]) sched.delete(gone[g]);
    end
    if (c == RD)
      for (int i = 0; i < BL; i++) sched[edge_no + CL + i] = key(b, open_row[b], wcol(a, i));
    if (c == PRE)
      for (int bb = 0; bb < BANKS; bb++) if (all || bb == b) pre_last[bb] = edge_no;
    if (c == ACT) open_row[b] = a % ROWS;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(NOP);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
    for (int b = 0; b < BANKS; b++) begin
      open_row[b] = 0; wr_last[b] = -1000; pre_last[b] = -1000;
    end
    rst_n = 1'b0; cmd = NOP; bank = '0; addr = '0; pre_all = 0; dqm = 0;
    dq_in = '0; dq_drv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "dq_oe in reset", dq_oe, 0);
    chk("R1", "dq_out in reset", dq_out, 0);
    rst_n = 1'b1;

    cur = "R1";
    idle(2);
    cyc(ACT, 1, 3); idle(3);
    cyc(RD, 1, 0); idle(6);

    cur = "R2";
    cyc(ACT, 0, 1); idle(2);
    cyc(WR, 0, 2, 0, 0, 16'hA000, 1);
    cyc(NOP, 0, 0, 0, 0, 16'hA001, 1);
    cyc(NOP, 0, 0, 0, 0, 16'hA002, 1);
    cyc(NOP, 0, 0, 0, 0, 16'hA003, 1);
    idle(2);
    cyc(RD, 0, 2); idle(6);
    cyc(RD, 0, 0); idle(6);

    cur = "R3";
    cyc(WR, 0, 4, 0, 0, 16'hB000, 1);
    cyc(NOP, 0, 0, 0, 1, 16'hB001, 1);
    cyc(NOP, 0, 0, 0, 0, 16'hB002, 1);
    cyc(NOP, 0, 0, 0, 1, 16'hB003, 1);
    idle(2);
    cyc(RD, 0, 4); idle(6);

    cur = "R4";
    cyc(WR, 0, 8, 0, 0, 16'hC000, 1);
    cyc(NOP, 0, 0, 0, 0, 16'hC001, 1);
    cyc(WR, 0, 12, 0, 0, 16'hD000, 1);
    cyc(NOP, 0, 0, 0, 0, 16'hD001, 1);
    cyc(NOP, 0, 0, 0, 0, 16'hD002, 1);
    cyc(NOP, 0, 0, 0, 0, 16'hD003, 1);
    idle(2);
    cyc(RD, 0, 8); idle(3);
    cyc(RD, 0, 12); idle(6);

    cur = "R5";
    cyc(WR, 0, 0, 0, 0, 16'hE000, 1);
    cyc(RD, 0, 0, 0, 0, 16'hE001, 1);
    cyc(NOP, 0, 0, 0, 0, 16'hE002, 1);
    idle(6);

    cur = "R6";
    cyc(RD, 0, 2); idle(3);
    cyc(WR, 0, 4, 0, 1);
    cyc(NOP, 0, 0, 0, 1, 16'h6001, 1);
    idle(4);

    cur = "R7";
    cyc(RD, 0, 4);
    cyc(NOP, 0, 0, 0, 0, '0, 1);
    cyc(NOP, 0, 0, 0, 0, '0, 1);
    cyc(NOP, 0, 0, 0, 0, '0, 1);
    idle(5);

    cur = "R8";
    cyc(ACT, 1, 0); idle(3);
    cyc(WR, 0, 8, 0, 0, 16'hF000, 1);
    cyc(PRE, 1, 0, 0, 0, 16'hF001, 1);
    cyc(NOP, 0, 0, 0, 0, 16'hF002, 1);
    cyc(NOP, 0, 0, 0, 0, 16'hF003, 1);
    idle(2);
    cyc(WR, 0, 12, 0, 0, 16'h9000, 1);
    cyc(NOP, 0, 0, 0, 0, 16'h9001, 1);
    cyc(PRE, 0, 0, 0, 1, 16'h9002, 1);
    idle(3);
    cyc(RD, 0, 12); idle(6);
    cyc(RD, 0, 8); idle(6);

    cur = "R9";
    cyc(ACT, 0, 1); idle(2);
    cyc(WR, 0, 0, 0, 0, 16'h7000, 1);
    cyc(NOP, 0, 0, 0, 0, 16'h7001, 1);
    cyc(NOP, 0, 0, 0, 0, 16'h7002, 1);
    cyc(NOP, 0, 0, 0, 1, 16'h7003, 1);
    cyc(PRE, 0, 0); idle(3);
    cyc(ACT, 0, 1); idle(3);
    cyc(WR, 0, 4, 0, 0, 16'h7100, 1);
    cyc(NOP, 0, 0, 0, 0, 16'h7101, 1);
    cyc(NOP, 0, 0, 0, 0, 16'h7102, 1);
    cyc(NOP, 0, 0, 0, 0, 16'h7103, 1);
    cyc(PRE, 0, 0); idle(3);
    cyc(ACT, 0, 1); idle(3);
    cyc(WR, 1, 0, 0, 0, 16'h7200, 1);
    cyc(PRE, 0, 0, 1, 1); idle(3);

    cur = "R10";
    cyc(PRE, 0, 0);
    cyc(ACT, 1, 2);
    cyc(ACT, 0, 1);
    cyc(ACT, 0, 1);
    cyc(ACT, 0, 1);
    idle(2);
    cyc(RD, 0, 0); idle(6);

    finish_run();
  end
endmodule